// File: doc/BRIEF.md
# ECC Error Log and Interrupt Register Block

This block sits next to the ECC checker of an on-chip memory. The checker reports two kinds of event, each as a one-cycle pulse. A correctable event covers a single-bit fix. An uncorrectable event covers a multi-bit failure. Each pulse carries the byte offset of the failing access within the memory window and the 64-bit data word involved. The block keeps one capture set per event class. Each capture set holds the first failing event until software acknowledges it. The block also keeps per-class pending flags and an interrupt mask, and drives a single level-sensitive interrupt line.

Software reaches the block through a plain 32-bit register port. The port has a write strobe, a read strobe, a byte address, write data and combinational read data. Neither the register port nor the event inputs use back-pressure. Every event pulse and every register access is taken in the cycle it is presented, so the checker never has to wait. Interrupt sources are unmasked by writing 1s to an enable register and masked again by writing 1s to a separate disable register. The mask itself can only be read. Pending flags are cleared by writing 1s to them. The window base address is not stored; software adds it back to the captured offset.

Top module: `ecc_log_regs`

## Requirements
- R1: Register offsets are 0x04 pending, 0x08 mask, 0x0C enable, 0x10 disable and 0x14 ECC control. Reads of 0x00, of 0x0C, of 0x10 and of any unmapped byte address return 0. Writes to 0x00, to the mask and to the capture registers have no effect. The read data is 0 whenever the read strobe is low.
- R2: Bit 0 of 0x14 is the ECC enable, which can be read and written and resets to 0. While it is 0, event pulses change neither the pending flags nor the captures.
- R3: With ECC enabled, a correctable pulse sets pending bit 6 and an uncorrectable pulse sets pending bit 7 on the next clock edge.
- R4: Writing 1 to bit 6 or bit 7 of 0x04 clears that pending bit, and writing 0 leaves it unchanged. If a pulse of the same class arrives in the same cycle as the clearing write, the bit stays set.
- R5: The mask resets to 0xC0, with both sources masked. Writing a 1 to bit 6 or 7 of 0x0C clears that mask bit. Writing a 1 to the same bit of 0x10 sets it again. A 0 written to either register leaves the mask unchanged.
- R6: The interrupt output is high exactly when some pending bit among bits 6 and 7 has its mask bit clear.
- R7: The correctable capture set reads at 0x1C (failing byte offset, zero-extended), 0x20 (data bits 31:0) and 0x24 (data bits 63:32). The uncorrectable set reads the same fields at 0x34, 0x38 and 0x3C.
- R8: A capture set loads only when its pending bit is clear. It holds the first event until that bit is cleared.
- R9: Correctable and uncorrectable pulses in the same cycle set both pending bits and load both capture sets from the same event data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ce_evt_i | input | 1 | Correctable-event pulse from the ECC checker |
| ue_evt_i | input | 1 | Uncorrectable-event pulse from the ECC checker |
| evt_addr_i | input | ADDR_W | Byte offset of the failing access within the memory window |
| evt_data_i | input | 64 | Data word of the failing access |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check on every cycle that:
- an enabled pulse sets its pending bit;
- pending bits stay clear while ECC is off;
- a pending bit survives any cycle without a clearing write and falls after a clearing write that has no competing pulse;
- a capture set holds steady while its pending bit is set;
- enable and disable writes move the mask;
- the interrupt drops once both sources are disabled or nothing is pending.

Only the bench scenarios can show that reads return the right field at each byte address, that writes to read-only registers are ignored, and that the data captured is that of the first event rather than a later one. The bench sweeps the full address space after each of a series of event, clear and mask patterns.

// File: rtl/ecc_log_pkg.sv
`timescale 1ns/1ps
package ecc_log_pkg;
  localparam int REG_W  = 32;
  localparam int RADR_W = 8;
  localparam int DATA_W = 64;
  localparam int NCLS   = 2;   // event classes: 0 correctable, 1 uncorrectable

  // bit position of each class inside pending/mask/enable/disable
  localparam int CE_BIT = 6;
  localparam int UE_BIT = 7;

  localparam logic [RADR_W-1:0] OFS_PEND  = 8'h04;
  localparam logic [RADR_W-1:0] OFS_MASK  = 8'h08;
  localparam logic [RADR_W-1:0] OFS_UNMSK = 8'h0C;
  localparam logic [RADR_W-1:0] OFS_DOMSK = 8'h10;
  localparam logic [RADR_W-1:0] OFS_ECTL  = 8'h14;
  localparam logic [RADR_W-1:0] OFS_CE_A  = 8'h1C;
  localparam logic [RADR_W-1:0] OFS_CE_DL = 8'h20;
  localparam logic [RADR_W-1:0] OFS_CE_DH = 8'h24;
  localparam logic [RADR_W-1:0] OFS_UE_A  = 8'h34;
  localparam logic [RADR_W-1:0] OFS_UE_DL = 8'h38;
  localparam logic [RADR_W-1:0] OFS_UE_DH = 8'h3C;

  typedef struct packed {
    logic [REG_W-1:0]  addr;
    logic [DATA_W-1:0] data;
  } cap_rec_t;
endpackage

// File: rtl/ecc_log_capture.sv
`timescale 1ns/1ps
module ecc_log_capture
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  output cap_rec_t            rec_o
);
  localparam int PAD_W = REG_W - ADDR_W;

  cap_rec_t rec_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rec_q <= '0;
    end else if (load_i) begin
      rec_q.addr <= {{PAD_W{1'b0}}, addr_i};
      rec_q.data <= data_i;
    end
  end

  assign rec_o = rec_q;
endmodule

// File: rtl/ecc_log_irq.sv
`timescale 1ns/1ps
module ecc_log_irq
  import ecc_log_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCLS-1:0] evt_i,      // already qualified by ECC enable
  input  logic            clr_wr_i,
  input  logic            unmask_wr_i,
  input  logic            domask_wr_i,
  input  logic [NCLS-1:0] wbits_i,
  output logic [NCLS-1:0] pend_o,
  output logic [NCLS-1:0] mask_o,
  output logic            irq_o
);
  logic [NCLS-1:0] pend_q, mask_q;
  logic [NCLS-1:0] clr_bits;

  assign clr_bits = clr_wr_i ? wbits_i : '0;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      // a same-cycle event wins over the clearing write
      pend_q <= (pend_q & ~clr_bits) | evt_i;
      if (unmask_wr_i)      mask_q <= mask_q & ~wbits_i;
      else if (domask_wr_i) mask_q <= mask_q | wbits_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & ~mask_q);
endmodule

// File: rtl/ecc_log_regs.sv
`timescale 1ns/1ps
module ecc_log_regs
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 18   // must be below 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_evt_i,
  input  logic              ue_evt_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  input  logic [63:0]       evt_data_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  logic            ecc_en_q;
  logic [NCLS-1:0] evt_w, pend_w, mask_w, load_w, wbits_w;
  cap_rec_t        rec_w [NCLS];
  logic            unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[31:8], reg_wdata_i[5:1]};
  assign wbits_w = {reg_wdata_i[UE_BIT], reg_wdata_i[CE_BIT]};
  assign evt_w   = {ue_evt_i, ce_evt_i} & {NCLS{ecc_en_q}};
  assign load_w  = evt_w & ~pend_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                                   ecc_en_q <= 1'b0;
    else if (reg_wr_i && reg_addr_i == OFS_ECTL)   ecc_en_q <= reg_wdata_i[0];
  end

  ecc_log_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_w),
    .clr_wr_i    (reg_wr_i && reg_addr_i == OFS_PEND),
    .unmask_wr_i (reg_wr_i && reg_addr_i == OFS_UNMSK),
    .domask_wr_i (reg_wr_i && reg_addr_i == OFS_DOMSK),
    .wbits_i     (wbits_w),
    .pend_o      (pend_w),
    .mask_o      (mask_w),
    .irq_o       (irq_o)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_cap
    ecc_log_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_w[c]),
      .addr_i (evt_addr_i),
      .data_i (evt_data_i),
      .rec_o  (rec_w[c])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      case (reg_addr_i)
        OFS_PEND: begin
          reg_rdata_o[CE_BIT] = pend_w[0];
          reg_rdata_o[UE_BIT] = pend_w[1];
        end
        OFS_MASK: begin
          reg_rdata_o[CE_BIT] = mask_w[0];
          reg_rdata_o[UE_BIT] = mask_w[1];
        end
        OFS_ECTL:  reg_rdata_o[0] = ecc_en_q;
        OFS_CE_A:  reg_rdata_o = rec_w[0].addr;
        OFS_CE_DL: reg_rdata_o = rec_w[0].data[31:0];
        OFS_CE_DH: reg_rdata_o = rec_w[0].data[63:32];
        OFS_UE_A:  reg_rdata_o = rec_w[1].addr;
        OFS_UE_DL: reg_rdata_o = rec_w[1].data[31:0];
        OFS_UE_DH: reg_rdata_o = rec_w[1].data[63:32];
        default:   reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ecc_log_sva.sv
`timescale 1ns/1ps
module ecc_log_sva
  import ecc_log_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ce_evt_i,
  input logic        ue_evt_i,
  input logic        reg_wr_i,
  input logic [7:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic        ecc_en,
  input logic [1:0]  pend,
  input logic [1:0]  mask,
  input logic        irq_o,
  input cap_rec_t    ce_rec,
  input cap_rec_t    ue_rec
);
  logic clr_ce, clr_ue;
  assign clr_ce = reg_wr_i && reg_addr_i == OFS_PEND && reg_wdata_i[CE_BIT];
  assign clr_ue = reg_wr_i && reg_addr_i == OFS_PEND && reg_wdata_i[UE_BIT];

  p_ce_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_en && ce_evt_i |=> pend[0]);
  p_ue_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_en && ue_evt_i |=> pend[1]);
  p_off_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ecc_en && pend == 2'b00 |=> pend == 2'b00);
  p_ce_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[0] && !clr_ce |=> pend[0]);
  p_ce_cleared_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ce && !ce_evt_i |=> !pend[0]);
  p_ue_cleared_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ue && !ue_evt_i |=> !pend[1]);
  p_unmask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == OFS_UNMSK && reg_wdata_i[CE_BIT] |=> !mask[0]);
  p_domask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == OFS_DOMSK && reg_wdata_i[UE_BIT] |=> mask[1]);
  p_all_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == OFS_DOMSK && reg_wdata_i[7:6] == 2'b11 |=> !irq_o);
  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend == 2'b00 |-> !irq_o);
  p_ce_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[0] |=> $stable(ce_rec));
  p_ue_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[1] |=> $stable(ue_rec));
endmodule

bind ecc_log_regs ecc_log_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_evt_i    (ce_evt_i),
  .ue_evt_i    (ue_evt_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .ecc_en      (ecc_en_q),
  .pend        (pend_w),
  .mask        (mask_w),
  .irq_o       (irq_o),
  .ce_rec      (rec_w[0]),
  .ue_rec      (rec_w[1])
);

// File: tb/ecc_log_regs_test.sv
`timescale 1ns/1ps
module ecc_log_regs_test;
  localparam int AW = 18;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic          rst_n, ce, ue, wr, rd, irq;
  logic [AW-1:0] ea;
  logic [63:0]   ed;
  logic [7:0]    ra;
  logic [31:0]   wd, rdat;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model, built from the requirements
  logic [1:0]  m_pend, m_mask;
  logic        m_en;
  logic [31:0] m_cea, m_uea;
  logic [63:0] m_ced, m_ued;

  ecc_log_regs #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_evt_i(ce), .ue_evt_i(ue),
    .evt_addr_i(ea), .evt_data_i(ed), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(ra), .reg_wdata_i(wd), .reg_rdata_o(rdat), .irq_o(irq)
  );

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h04: return {24'b0, m_pend, 6'b0};
      8'h08: return {24'b0, m_mask, 6'b0};
      8'h14: return {31'b0, m_en};
      8'h1C: return m_cea;
      8'h20: return m_ced[31:0];
      8'h24: return m_ced[63:32];
      8'h34: return m_uea;
      8'h38: return m_ued[31:0];
      8'h3C: return m_ued[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock cycle of stimulus, with the model advanced at the edge
  task automatic step(logic w, logic [7:0] a, logic [31:0] d,
                      logic c, logic u, logic [AW-1:0] adr, logic [63:0] dat);
    logic [1:0] ev, clr;
    @(negedge clk);
    wr = w; ra = a; wd = d; ce = c; ue = u; ea = adr; ed = dat;
    @(posedge clk);
    ev  = {u, c} & {2{m_en}};
    clr = (w && a == 8'h04) ? d[7:6] : 2'b00;
    if (ev[0] && !m_pend[0]) begin m_cea = 32'(adr); m_ced = dat; end
    if (ev[1] && !m_pend[1]) begin m_uea = 32'(adr); m_ued = dat; end
    m_pend = (m_pend & ~clr) | ev;
    if (w && a == 8'h0C) m_mask = m_mask & ~d[7:6];
    if (w && a == 8'h10) m_mask = m_mask | d[7:6];
    if (w && a == 8'h14) m_en = d[0];
    #1;
    wr = 0; ce = 0; ue = 0;
  endtask

  task automatic wreg(logic [7:0] a, logic [31:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic evt(logic c, logic u, logic [AW-1:0] adr, logic [63:0] dat);
    step(1'b0, 8'h00, 32'h0, c, u, adr, dat);
  endtask

  task automatic rd_check(logic [7:0] a, string req);
    @(negedge clk);
    rd = 1'b1; ra = a;
    #1;
    check(req, $sformatf("read 0x%02h", a), rdat, exp_rd(a));
    rd = 1'b0;
  endtask

  task automatic sweep(string req, int last);
    for (int a = 0; a <= last; a++) rd_check(8'(a), req);
  endtask

  task automatic irq_check(string req);
    @(negedge clk);
    check(req, "irq", {31'b0, irq}, {31'b0, |(m_pend & ~m_mask)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce = 0; ue = 0; wr = 0; rd = 0; ea = '0; ed = '0; ra = '0; wd = '0;
    m_pend = 2'b00; m_mask = 2'b11; m_en = 0;
    m_cea = 0; m_uea = 0; m_ced = 0; m_ued = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 R5: reset state over every byte address; rd low gives zero
    sweep("R1", 255);
    irq_check("R6");
    @(negedge clk); ra = 8'h08;
    #1 check("R1", "rdata with read strobe low", rdat, 32'h0);

    // R2: events ignored while ECC is off
    evt(1, 1, 18'h2ABC4, 64'h1111_2222_3333_4444);
    sweep("R2", 63);
    wreg(8'h14, 32'h1);
    rd_check(8'h14, "R2");

    // R3 R7: first correctable event captured, masked so no irq
    evt(1, 0, 18'h00A48, 64'hDEAD_BEEF_0BAD_F00D);
    sweep("R7", 63);
    irq_check("R6");
    // R8: second event does not overwrite
    evt(1, 0, 18'h3FFFC, 64'hFFFF_0000_FFFF_0000);
    sweep("R8", 63);

    // R5 R6: unmask correctable
    wreg(8'h0C, 32'h40);
    rd_check(8'h08, "R5");
    irq_check("R6");
    // R1: writes to mask and captures ignored
    wreg(8'h08, 32'hFFFF_FFFF);
    wreg(8'h1C, 32'hFFFF_FFFF);
    wreg(8'h38, 32'hFFFF_FFFF);
    wreg(8'h00, 32'hFFFF_FFFF);
    sweep("R1", 63);

    // R4: writing zero keeps, writing one clears
    wreg(8'h04, 32'h0);
    rd_check(8'h04, "R4");
    wreg(8'h04, 32'h40);
    rd_check(8'h04, "R4");
    irq_check("R6");

    // R4: clear and new event in the same cycle
    evt(1, 0, 18'h00100, 64'h0123_4567_89AB_CDEF);
    step(1, 8'h04, 32'h40, 1, 0, 18'h00200, 64'h5555_AAAA_5555_AAAA);
    sweep("R4", 63);
    wreg(8'h04, 32'hC0);

    // R9: both classes in the same cycle
    evt(1, 1, 18'h1F00C, 64'hCAFE_0001_BEEF_0002);
    sweep("R9", 63);

    // R5: disable masks again
    wreg(8'h10, 32'h40);
    rd_check(8'h08, "R5");
    irq_check("R6");
    wreg(8'h04, 32'hC0);

    // sweep of event, clear and mask combinations
    for (int i = 0; i < 32; i++) begin
      logic [AW-1:0] adr;
      logic [63:0]   dat;
      adr = AW'(i * 32'h0000_1F3C + 32'h44);
      dat = {32'(i) * 32'h9E37_79B9, ~(32'(i) * 32'h0101_0101)};
      if (i[3]) wreg(8'h0C, {24'b0, i[4], i[2], 6'b0});
      else      wreg(8'h10, {24'b0, i[4], i[2], 6'b0});
      step(i[2], 8'h04, {24'b0, i[4], i[1], 6'b0}, i[0], i[1], adr, dat);
      sweep("R8", 63);
      irq_check("R6");
      if (i % 8 == 7) wreg(8'h14, {31'b0, ~m_en});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule